// File: doc/BRIEF.md
# Prioritised Queue-to-Channel Transmit Scheduler

This block decides which transmit queue is served next and which DMA FIFO channel its frame request is sent to. Each of up to sixteen queues has a programmable channel assignment, an active flag, a scheduling enable and a pending-frame input. Several queues may share one channel. The block first picks the winning channel by fixed priority. It then picks one queue on that channel by round robin, and offers the result on a valid/ready output.

Software programs the queues through a single write port. That port carries either a status word (channel, active flag, scheduling enable) or a context word (transmit window and frame limit, each at most 64). The window and frame limit of the winning queue travel with the grant, so the downstream DMA logic receives them together with the queue index.

Top module: `txq_prio_sched`

## Requirements
- R1: After reset `grant_valid` is 0. Every queue is inactive, with channel 0, window 0 and frame limit 0.
- R2: A write with `cfg_sel`=0 loads the status word of queue `cfg_qidx`. Bits 2:0 hold the channel, bit 3 the active flag and bit 19 the scheduling enable. A queue is eligible only when it is active, enabled and its `q_pend` bit is 1.
- R3: A write with `cfg_sel`=1 loads the context word. Bits 6:0 hold the window and bits 22:16 the frame limit. Any value above 64 is stored as 64. The stored pair of the granted queue appears on `grant_win` and `grant_flim`.
- R4: Channel priority, from highest to lowest, is 7 (commands), 3, 2, 1, 0.
- R5: Channels 4, 5 and 6 never produce a grant, even when an eligible queue is mapped to them.
- R6: Queues on one channel are served in round robin. After a completed handshake for queue q, the search on that channel starts at q+1 and wraps from 15 to 0. The start point changes only on a completed handshake.
- R7: While `grant_valid` is 1 and `grant_ready` is 0, all grant outputs hold their values, whatever the inputs do.
- R8: A grant is registered one clock after an eligible queue is seen while no grant is outstanding. After a handshake, `grant_valid` is 0 for exactly one cycle before the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = status word, 1 = context word |
| cfg_qidx | input | 4 | Queue being written |
| cfg_wdata | input | 32 | Configuration word |
| q_pend | input | 16 | Per-queue frame-pending flags |
| grant_valid | output | 1 | Grant offered |
| grant_ready | input | 1 | Grant accepted by the consumer |
| grant_queue | output | 4 | Winning queue index |
| grant_chan | output | 3 | DMA FIFO channel of the winning queue |
| grant_win | output | 7 | Window size of the winning queue |
| grant_flim | output | 7 | Frame limit of the winning queue |

## Verification
With every queue pending, the grant order shows whether channel ranking puts the command channel first and walks down to channel 0. Inactive and disabled queues are set pending along the way, which shows that they are skipped. Re-raising three queues that share channel 1 in different subsets separates a correct round-robin start point, including its wrap, from a fixed lowest-index pick. A grant held under back-pressure while higher-priority requests arrive separates a registered, frozen grant from one that follows its inputs. A queue mapped to an unused channel is left pending to show that no grant ever appears for it.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int WORD_W      = 32;
    localparam int CTX_W       = 7;
    localparam int CTX_MAX     = 64;
    localparam int STS_ACT_BIT = 3;
    localparam int STS_EN_BIT  = 19;
    localparam int CTX_WIN_LSB = 0;
    localparam int CTX_FL_LSB  = 16;

    typedef enum logic {
        SEL_STATUS  = 1'b0,
        SEL_CONTEXT = 1'b1
    } cfg_sel_e;

    function automatic logic [CTX_W-1:0] clamp_ctx(input logic [CTX_W-1:0] v);
        return (v > CTX_W'(CTX_MAX)) ? CTX_W'(CTX_MAX) : v;
    endfunction
endpackage

// File: rtl/sched_cfg_regs.sv
module sched_cfg_regs
    import sched_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int CH_W  = 3,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic                            sel,
    input  logic [QW-1:0]                   idx,
    input  logic [WORD_W-1:0]               wdata,
    output logic [NUM_Q-1:0][CH_W-1:0]      q_chan,
    output logic [NUM_Q-1:0]                q_ok,
    output logic [NUM_Q-1:0][CTX_W-1:0]     q_win,
    output logic [NUM_Q-1:0][CTX_W-1:0]     q_flim
);
    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic             act;
        logic             en;
        logic [CTX_W-1:0] win;
        logic [CTX_W-1:0] flim;
    } qcfg_t;

    qcfg_t [NUM_Q-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (cfg_sel_e'(sel) == SEL_STATUS) begin
                cfg_d[idx].chan = wdata[CH_W-1:0];
                cfg_d[idx].act  = wdata[STS_ACT_BIT];
                cfg_d[idx].en   = wdata[STS_EN_BIT];
            end else begin
                cfg_d[idx].win  = clamp_ctx(wdata[CTX_WIN_LSB +: CTX_W]);
                cfg_d[idx].flim = clamp_ctx(wdata[CTX_FL_LSB +: CTX_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_out
        assign q_chan[q] = cfg_q[q].chan;
        assign q_ok[q]   = cfg_q[q].act & cfg_q[q].en;
        assign q_win[q]  = cfg_q[q].win;
        assign q_flim[q] = cfg_q[q].flim;
    end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
    parameter int NUM_Q = 16,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] req,
    input  logic [QW-1:0]    start,
    output logic             hit,
    output logic [QW-1:0]    idx
);
    // Walk offsets from far to near so the nearest request to start wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = NUM_Q - 1; k >= 0; k--) begin
            int p;
            p = int'(start) + k;
            if (p >= NUM_Q) p = p - NUM_Q;
            if (req[p]) begin
                hit = 1'b1;
                idx = QW'(p);
            end
        end
    end
endmodule

// File: rtl/sched_chan_pick.sv
module sched_chan_pick #(
    parameter int             NUM_CH    = 8,
    parameter int             CMD_CH    = 7,
    parameter logic [NUM_CH-1:0] USED_MASK = 8'b1000_1111,
    localparam int            CH_W      = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] ch_req,
    output logic              hit,
    output logic [CH_W-1:0]   ch
);
    // Higher index ranks higher among data channels; the command channel tops all.
    always_comb begin
        hit = 1'b0;
        ch  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (c != CMD_CH && USED_MASK[c] && ch_req[c]) begin
                hit = 1'b1;
                ch  = CH_W'(c);
            end
        end
        if (USED_MASK[CMD_CH] && ch_req[CMD_CH]) begin
            hit = 1'b1;
            ch  = CH_W'(CMD_CH);
        end
    end
endmodule

// File: rtl/txq_prio_sched.sv
module txq_prio_sched
    import sched_pkg::*;
#(
    parameter int                NUM_Q     = 16,
    parameter int                NUM_CH    = 8,
    parameter int                CMD_CH    = 7,
    parameter logic [NUM_CH-1:0] USED_MASK = 8'b1000_1111,
    localparam int               QW        = $clog2(NUM_Q),
    localparam int               CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [QW-1:0]     cfg_qidx,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [NUM_Q-1:0]  q_pend,
    output logic              grant_valid,
    input  logic              grant_ready,
    output logic [QW-1:0]     grant_queue,
    output logic [CH_W-1:0]   grant_chan,
    output logic [CTX_W-1:0]  grant_win,
    output logic [CTX_W-1:0]  grant_flim
);
    logic [NUM_Q-1:0][CH_W-1:0]  q_chan;
    logic [NUM_Q-1:0]            q_ok;
    logic [NUM_Q-1:0][CTX_W-1:0] q_win;
    logic [NUM_Q-1:0][CTX_W-1:0] q_flim;

    sched_cfg_regs #(.NUM_Q(NUM_Q), .CH_W(CH_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .idx    (cfg_qidx),
        .wdata  (cfg_wdata),
        .q_chan (q_chan),
        .q_ok   (q_ok),
        .q_win  (q_win),
        .q_flim (q_flim)
    );

    typedef struct packed {
        logic                       valid;
        logic [QW-1:0]              queue;
        logic [CH_W-1:0]            chan;
        logic [CTX_W-1:0]           win;
        logic [CTX_W-1:0]           flim;
        logic [NUM_CH-1:0][QW-1:0]  ptr;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CH-1:0][NUM_Q-1:0] req_mat;
    logic [NUM_CH-1:0]            rr_hit;
    logic [NUM_CH-1:0][QW-1:0]    rr_idx;
    logic                         any_hit;
    logic [CH_W-1:0]              sel_ch;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            for (int q = 0; q < NUM_Q; q++)
                req_mat[c][q] = q_pend[q] & q_ok[q] & (q_chan[q] == CH_W'(c));
        end
        sched_rr_pick #(.NUM_Q(NUM_Q)) u_rr (
            .req   (req_mat[c]),
            .start (st_q.ptr[c]),
            .hit   (rr_hit[c]),
            .idx   (rr_idx[c])
        );
    end

    sched_chan_pick #(.NUM_CH(NUM_CH), .CMD_CH(CMD_CH), .USED_MASK(USED_MASK)) u_chan (
        .ch_req (rr_hit),
        .hit    (any_hit),
        .ch     (sel_ch)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.valid) begin
            if (grant_ready) begin
                st_d.valid = 1'b0;
                st_d.ptr[st_q.chan] = (st_q.queue == QW'(NUM_Q - 1)) ? '0 : st_q.queue + 1'b1;
            end
        end else if (any_hit) begin
            st_d.valid = 1'b1;
            st_d.queue = rr_idx[sel_ch];
            st_d.chan  = sel_ch;
            st_d.win   = q_win[rr_idx[sel_ch]];
            st_d.flim  = q_flim[rr_idx[sel_ch]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid = st_q.valid;
    assign grant_queue = st_q.queue;
    assign grant_chan  = st_q.chan;
    assign grant_win   = st_q.win;
    assign grant_flim  = st_q.flim;
endmodule

// File: rtl/txq_prio_sched_chk.sv
module txq_prio_sched_chk #(
    parameter int                NUM_Q     = 16,
    parameter int                NUM_CH    = 8,
    parameter int                CMD_CH    = 7,
    parameter logic [NUM_CH-1:0] USED_MASK = 8'b1000_1111,
    localparam int               QW        = $clog2(NUM_Q),
    localparam int               CH_W      = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant_valid,
    input logic              grant_ready,
    input logic [QW-1:0]     grant_queue,
    input logic [CH_W-1:0]   grant_chan,
    input logic [6:0]        grant_win,
    input logic [6:0]        grant_flim,
    input logic [NUM_Q-1:0]  q_pend,
    input logic [NUM_CH-1:0] rr_hit
);
    logic [NUM_Q-1:0] pend_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_prev <= '0;
        else        pend_prev <= q_pend;
    end

    AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_ready |=> grant_valid && $stable(grant_queue) && $stable(grant_chan) && $stable(grant_win) && $stable(grant_flim)); // R7

    AST_NO_UNUSED_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> USED_MASK[grant_chan]); // R5

    AST_CTX_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_win <= 7'd64) && (grant_flim <= 7'd64)); // R3

    AST_WINNER_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> pend_prev[grant_queue]); // R2

    AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && $past(rr_hit[CMD_CH]) |-> grant_chan == CH_W'(CMD_CH)); // R4

    AST_BUBBLE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_ready |=> !grant_valid); // R8
endmodule

bind txq_prio_sched txq_prio_sched_chk #(
    .NUM_Q(NUM_Q), .NUM_CH(NUM_CH), .CMD_CH(CMD_CH), .USED_MASK(USED_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .grant_ready (grant_ready),
    .grant_queue (grant_queue),
    .grant_chan  (grant_chan),
    .grant_win   (grant_win),
    .grant_flim  (grant_flim),
    .q_pend      (q_pend),
    .rr_hit      (rr_hit)
);

// File: tb/tb_txq_prio_sched.sv
module tb_txq_prio_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [3:0]  cfg_qidx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] q_pend = '0;
    logic        grant_ready = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_queue;
    logic [2:0]  grant_chan;
    logic [6:0]  grant_win, grant_flim;

    always #5 clk = ~clk;

    txq_prio_sched dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_qidx(cfg_qidx), .cfg_wdata(cfg_wdata), .q_pend(q_pend),
        .grant_valid(grant_valid), .grant_ready(grant_ready),
        .grant_queue(grant_queue), .grant_chan(grant_chan),
        .grant_win(grant_win), .grant_flim(grant_flim)
    );

    typedef struct {
        logic [3:0] q;
        logic [2:0] c;
        logic [6:0] w;
        logic [6:0] f;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    n_run = 0;
    int    n_fail = 0;

    // Bench-side model of the programmed state
    int b_chan[16];
    bit b_act[16];
    bit b_en[16];
    int b_win[16];
    int b_flim[16];
    int b_ptr[8];

    function automatic int capv(int v);
        return (v > 64) ? 64 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic wr_status(input int q, input int ch, input bit act, input bit en);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_qidx = 4'(q);
        cfg_wdata = (32'(en) << 19) | (32'(act) << 3) | 32'(ch);
        tick();
        cfg_we = 1'b0;
        b_chan[q] = ch; b_act[q] = act; b_en[q] = en;
    endtask

    task automatic wr_ctx(input int q, input int w, input int f);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_qidx = 4'(q);
        cfg_wdata = (32'(f) << 16) | 32'(w);
        tick();
        cfg_we = 1'b0;
        b_win[q] = capv(w); b_flim[q] = capv(f);
    endtask

    function automatic bit model(output int wq, output int wc);
        int order[5] = '{7, 3, 2, 1, 0};
        wq = 0; wc = 0;
        foreach (order[i]) begin
            for (int k = 0; k < 16; k++) begin
                int p;
                p = (b_ptr[order[i]] + k) % 16;
                if (q_pend[p] && b_act[p] && b_en[p] && b_chan[p] == order[i]) begin
                    wq = p; wc = order[i];
                    return 1'b1;
                end
            end
        end
        return 1'b0;
    endfunction

    // Serve one grant: predict, wait, optionally hold under back-pressure, accept.
    task automatic serve(input bit clr, input int lat, input int hold, input logic [15:0] hold_pend, input string tag);
        int   wq, wc, cnt;
        item_t e;
        if (!model(wq, wc)) begin
            check(1'b0, tag, "model found no winner", 0, 1);
            return;
        end
        e.q = 4'(wq); e.c = 3'(wc); e.w = 7'(b_win[wq]); e.f = 7'(b_flim[wq]); e.tag = tag;
        exp_q.push_back(e);
        cnt = 0;
        while (!grant_valid && cnt < 50) begin
            tick();
            cnt++;
        end
        if (lat >= 0) check(cnt == lat, "R8", "grant latency", cnt, lat);
        for (int h = 0; h < hold; h++) begin
            if (h == 0) q_pend = hold_pend;
            tick();
            check(grant_valid && grant_queue == e.q && grant_chan == e.c &&
                  grant_win == e.w && grant_flim == e.f, "R7", "held grant queue", int'(grant_queue), int'(e.q));
        end
        grant_ready = 1'b1;
        tick();
        grant_ready = 1'b0;
        if (clr) q_pend[wq] = 1'b0;
        b_ptr[wc] = (wq + 1) % 16;
    endtask

    task automatic idle_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            check(!grant_valid, tag, "grant_valid while nothing eligible", int'(grant_valid), 0);
        end
    endtask

    // Monitor: compares the offered grant when the handshake is about to complete.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && grant_valid && grant_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected grant queue", int'(grant_queue), -1);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(grant_queue == e.q, e.tag, "grant_queue", int'(grant_queue), int'(e.q));
                    check(grant_chan == e.c, e.tag, "grant_chan", int'(grant_chan), int'(e.c));
                    check(grant_win == e.w, "R3", "grant_win", int'(grant_win), int'(e.w));
                    check(grant_flim == e.f, "R3", "grant_flim", int'(grant_flim), int'(e.f));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            b_chan[i] = 0; b_act[i] = 0; b_en[i] = 0; b_win[i] = 0; b_flim[i] = 0;
        end
        for (int i = 0; i < 8; i++) b_ptr[i] = 0;

        repeat (3) tick();
        check(grant_valid == 1'b0, "R1", "grant_valid in reset", int'(grant_valid), 0);
        rst_n = 1'b1;
        tick();
        check(grant_valid == 1'b0, "R1", "grant_valid after reset", int'(grant_valid), 0);

        // Status words (R2): q6 inactive, q8 disabled, q4 on unused channel 5
        wr_status(0, 0, 1, 1);
        wr_status(1, 1, 1, 1);
        wr_status(2, 2, 1, 1);
        wr_status(3, 3, 1, 1);
        wr_status(4, 5, 1, 1);
        wr_status(5, 1, 1, 1);
        wr_status(6, 2, 0, 1);
        wr_status(7, 7, 1, 1);
        wr_status(8, 3, 1, 0);
        wr_status(9, 1, 1, 1);
        // Context words (R3), including values above the cap
        wr_ctx(0, 10, 20);
        wr_ctx(1, 100, 127);
        wr_ctx(3, 64, 3);

        // Phase A: all pending; priority walk 7, 3, 2, 1, 0 (R4, R2, R6)
        q_pend = 16'hFFFF;
        serve(1'b1, -1, 0, '0, "R4");
        serve(1'b1, 1, 0, '0, "R4");
        serve(1'b1, 1, 0, '0, "R2");
        serve(1'b1, 1, 0, '0, "R6");
        serve(1'b1, 1, 0, '0, "R6");
        serve(1'b1, 1, 0, '0, "R6");
        serve(1'b1, 1, 0, '0, "R4");
        // Left pending: q4 (channel 5), q6 inactive, q8 disabled, unconfigured queues
        idle_check(5, "R5");
        q_pend = 16'h0140;
        idle_check(3, "R2");

        // Phase B: round robin on channel 1 with wrap (R6)
        q_pend = 16'h0222;
        serve(1'b0, -1, 0, '0, "R6");
        serve(1'b1, 1, 0, '0, "R6");
        serve(1'b1, 1, 0, '0, "R6");
        serve(1'b1, 1, 0, '0, "R6");
        idle_check(2, "R6");

        // Phase C: back-pressure hold while a higher channel and pend drop arrive (R7)
        q_pend = 16'h0001;
        serve(1'b0, -1, 4, 16'h0080, "R7");
        serve(1'b1, 1, 0, '0, "R4");
        idle_check(2, "R8");

        tick();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule